// File: doc/BRIEF.md
# Cascadable Eight-Input Interrupt Controller

This block collects eight interrupt request lines and presents a single interrupt output to a processor. A host programs it through a two-address byte port. Writes to the even address carry either a restart command or operation commands. Writes to the odd address carry configuration bytes while initialization is in progress, and the mask byte once it has finished. The block keeps three 8-bit registers: pending requests, requests in service, and the mask. It picks the winning request by fixed priority, with input 0 the most urgent.

When the processor pulses the acknowledge input, the winning request moves from pending to in service. During that cycle `ack_vec` shows the programmed base with the input number in its low three bits. The cascade configuration byte is kept and driven out, so that two instances can be chained by surrounding logic. The host can also poll instead of taking interrupts, and it can switch to special mask mode, in which an in-service request blocks only itself.

Top module: `irq_ctl8`

## Requirements
- R1: An even-address write with bit 4 set restarts initialization and clears the mask, the in-service register, special mask mode and poll mode; readback select returns to pending requests. Bit 0 means a mode byte will follow, bit 1 means single (no cascade byte), and bit 3 selects level sensing instead of edge sensing. `intr` stays low until the sequence completes.
- R2: The first odd write after a restart sets the vector base. An acknowledged input n yields `ack_vec` = {base[7:3], n}, which is base+n for a base that is a multiple of 8.
- R3: A cascade byte is taken as the next odd write only when bit 1 of the restart byte was 0. It is driven on `cas_word`, and is skipped entirely in single mode.
- R4: A mode byte is taken last, and only when bit 0 of the restart byte was 1. Its bit 1 enables automatic end of interrupt.
- R5: After initialization, odd writes load the mask, where a 1 disables that input. Odd reads return the mask. After reset the mask is 0xFF and `intr` is low.
- R6: In edge mode a pending bit is set by a rising input and cleared by its acknowledge. In level mode the pending register follows the inputs, registered once per cycle.
- R7: `intr` is high when the highest-priority unmasked pending input (input 0 highest) has a lower index than every in-service bit. An acknowledge sets that input's in-service bit.
- R8: With automatic end of interrupt enabled, an acknowledge never sets an in-service bit.
- R9: An even write of 0x20 (bits 4:3 = 00, bits 7:5 = 001) clears the lowest-index in-service bit.
- R10: An even write with bit 4 = 0 and bit 3 = 1 is a command word. If its bits 1:0 are 10, even reads return the pending register; if they are 11, even reads return the in-service register; bits 1:0 = 0x leave the selection unchanged.
- R11: In that command word, bits 6:5 = 11 enter special mask mode and 10 leave it. In special mask mode an unmasked pending input is blocked only by its own in-service bit.
- R12: In that command word, bit 2 arms poll mode. The next even read returns {request present, 0000, winning input} and acts as an acknowledge, then disarms poll mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (needed for poll reads) |
| port_sel | input | 1 | 0 = even address, 1 = odd address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected address |
| irq_in | input | 8 | Interrupt request lines |
| intr | output | 1 | Interrupt request to the processor |
| inta | input | 1 | Acknowledge pulse, one cycle |
| ack_vec | output | 8 | Vector of the winning input, valid while `intr` is high |
| cas_word | output | 8 | Stored cascade configuration byte |

## Verification
Nested requests are raised in both directions. A less urgent input arriving behind an in-service one must stay silent, while a more urgent one must preempt it; this separates correct fixed-priority blocking from plain pending-bit arbitration. Masked inputs, special mask mode and poll reads each give a different answer to the same pending and in-service state, so each is exercised from a known in-service pattern. A second initialization in single, level-sensed, automatic-EOI mode uses a different vector base. It shows whether the byte sequence skipped the cascade byte, whether the pending register tracks a falling line, and whether in-service stays empty after an acknowledge.

// File: rtl/irq_ctl8_pkg.sv
package irq_ctl8_pkg;
  localparam int NIRQ = 8;
  localparam int IDW  = $clog2(NIRQ);

  typedef enum logic [1:0] {S_READY, S_BASE, S_CASC, S_MODE} init_st_t;

  // Index of the lowest set bit (most urgent); 0 when empty.
  function automatic logic [IDW-1:0] lowest_idx(input logic [NIRQ-1:0] v);
    logic [IDW-1:0] r;
    r = '0;
    for (int i = NIRQ - 1; i >= 0; i--)
      if (v[i]) r = IDW'(i);
    return r;
  endfunction

  // Vector = base with its low bits replaced by the input number.
  function automatic logic [7:0] make_vector(input logic [7:0] base,
                                             input logic [IDW-1:0] id);
    return {base[7:IDW], id};
  endfunction
endpackage

// File: rtl/irq_ctl8_init.sv
module irq_ctl8_init
  import irq_ctl8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart_wr,
  input  logic       odd_wr,
  input  logic [7:0] wdata,
  output logic       busy,
  output logic [7:0] base,
  output logic [7:0] cas,
  output logic       level_mode,
  output logic       aeoi
);
  init_st_t st;
  logic     need_mode, single;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_READY; need_mode <= 1'b0; single <= 1'b1;
      level_mode <= 1'b0; aeoi <= 1'b0; base <= '0; cas <= '0;
    end else if (restart_wr) begin
      st         <= S_BASE;
      need_mode  <= wdata[0];
      single     <= wdata[1];
      level_mode <= wdata[3];
      aeoi       <= 1'b0;
    end else if (odd_wr) begin
      case (st)
        S_BASE: begin
          base <= wdata;
          st   <= !single ? S_CASC : (need_mode ? S_MODE : S_READY);
        end
        S_CASC: begin
          cas <= wdata;
          st  <= need_mode ? S_MODE : S_READY;
        end
        S_MODE: begin
          aeoi <= wdata[1];
          st   <= S_READY;
        end
        default: ;
      endcase
    end
  end

  assign busy = (st != S_READY);
endmodule

// File: rtl/irq_ctl8_core.sv
module irq_ctl8_core
  import irq_ctl8_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] irq_in,
  input  logic            level_mode,
  input  logic            aeoi,
  input  logic            smm,
  input  logic            clear_all,
  input  logic            mask_wr,
  input  logic [NIRQ-1:0] mask_data,
  input  logic            ack,
  input  logic            eoi,
  output logic [NIRQ-1:0] irr,
  output logic [NIRQ-1:0] isr,
  output logic [NIRQ-1:0] imr,
  output logic            req,
  output logic [IDW-1:0]  win_id,
  output logic            ack_fire
);
  logic [NIRQ-1:0] irq_q, rise, cand, irr_nx, isr_nx;
  logic [IDW-1:0]  isr_top;
  logic            blocked;

  assign rise    = irq_in & ~irq_q;
  assign cand    = smm ? (irr & ~imr & ~isr) : (irr & ~imr);
  assign win_id  = lowest_idx(cand);
  assign isr_top = lowest_idx(isr);
  assign blocked = !smm && (|isr) && (isr_top <= win_id);
  assign req     = (|cand) && !blocked;
  assign ack_fire = ack && req;

  always_comb begin
    irr_nx = level_mode ? irq_in : (irr | rise);
    if (ack_fire && !level_mode) irr_nx[win_id] = 1'b0;
    isr_nx = isr;
    if (eoi && (|isr)) isr_nx[isr_top] = 1'b0;
    if (ack_fire && !aeoi) isr_nx[win_id] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= '0; irr <= '0; isr <= '0; imr <= '1;
    end else begin
      irq_q <= irq_in;
      if (clear_all) begin
        irr <= '0; isr <= '0; imr <= '0;
      end else begin
        irr <= irr_nx;
        isr <= isr_nx;
        if (mask_wr) imr <= mask_data;
      end
    end
  end
endmodule

// File: rtl/irq_ctl8.sv
module irq_ctl8
  import irq_ctl8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       port_sel,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] irq_in,
  output logic       intr,
  input  logic       inta,
  output logic [7:0] ack_vec,
  output logic [7:0] cas_word
);
  // Named internal events, brought out for the checker.
  logic            init_busy, aeoi_on, level_on, smm_q, rd_isr_q, poll_q;
  logic [7:0]      base_q;
  logic [NIRQ-1:0] irr_q, isr_q, imr_q;
  logic [IDW-1:0]  ack_id;
  logic            core_req, ack_fire;
  logic            wr_even, restart_wr, ocw3_wr, eoi_cmd, odd_wr, mask_wr;
  logic            poll_read, ack_any;

  assign wr_even    = wr_en && !port_sel;
  assign restart_wr = wr_even && wdata[4];
  assign ocw3_wr    = wr_even && !wdata[4] && wdata[3] && !init_busy;
  assign eoi_cmd    = wr_even && (wdata[4:3] == 2'b00) && (wdata[7:5] == 3'b001) && !init_busy;
  assign odd_wr     = wr_en && port_sel;
  assign mask_wr    = odd_wr && !init_busy;
  assign poll_read  = rd_en && !port_sel && poll_q;
  assign ack_any    = (inta || poll_read) && !init_busy;

  irq_ctl8_init u_init (
    .clk(clk), .rst_n(rst_n), .restart_wr(restart_wr), .odd_wr(odd_wr),
    .wdata(wdata), .busy(init_busy), .base(base_q), .cas(cas_word),
    .level_mode(level_on), .aeoi(aeoi_on)
  );

  irq_ctl8_core u_core (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_mode(level_on),
    .aeoi(aeoi_on), .smm(smm_q), .clear_all(restart_wr), .mask_wr(mask_wr),
    .mask_data(wdata), .ack(ack_any), .eoi(eoi_cmd), .irr(irr_q),
    .isr(isr_q), .imr(imr_q), .req(core_req), .win_id(ack_id),
    .ack_fire(ack_fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smm_q <= 1'b0; rd_isr_q <= 1'b0; poll_q <= 1'b0;
    end else if (restart_wr) begin
      smm_q <= 1'b0; rd_isr_q <= 1'b0; poll_q <= 1'b0;
    end else if (ocw3_wr) begin
      if (wdata[1]) rd_isr_q <= wdata[0];
      if (wdata[6]) smm_q    <= wdata[5];
      poll_q <= wdata[2];
    end else if (poll_read) begin
      poll_q <= 1'b0;
    end
  end

  assign intr    = core_req && !init_busy;
  assign ack_vec = make_vector(base_q, ack_id);

  always_comb begin
    if (port_sel)      rdata = imr_q;
    else if (poll_q)   rdata = {intr, 4'b0000, ack_id};
    else if (rd_isr_q) rdata = isr_q;
    else               rdata = irr_q;
  end
endmodule

// File: rtl/irq_ctl8_chk.sv
module irq_ctl8_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       intr,
  input logic       busy,
  input logic       aeoi,
  input logic       smm,
  input logic       eoi,
  input logic [7:0] irr,
  input logic [7:0] isr,
  input logic [7:0] imr,
  input logic       ack_fire,
  input logic [2:0] ack_id
);
  a_r1_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !intr);

  a_r5_ack_unmasked_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |-> (!imr[ack_id] && irr[ack_id]));

  a_r7_ack_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !aeoi) |=> (busy || isr[$past(ack_id)]));

  a_r7_priority_over_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (intr && !smm) |-> ((isr & (8'(8'd2 << ack_id) - 8'd1)) == 8'd0));

  a_r8_aeoi_no_new_isr: assert property (@(posedge clk) disable iff (!rst_n)
    aeoi |=> ((isr & ~$past(isr)) == 8'd0));

  a_r9_eoi_clears_one: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && (isr != 8'd0) && !ack_fire) |=> ($countones(isr) == $countones($past(isr)) - 1));
endmodule

bind irq_ctl8 irq_ctl8_chk u_chk (
  .clk(clk), .rst_n(rst_n), .intr(intr), .busy(init_busy), .aeoi(aeoi_on),
  .smm(smm_q), .eoi(eoi_cmd), .irr(irr_q), .isr(isr_q), .imr(imr_q),
  .ack_fire(ack_fire), .ack_id(ack_id)
);

// File: tb/test_irq_ctl8.sv
module test_irq_ctl8;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, port_sel = 1'b0, inta = 1'b0;
  logic [7:0] wdata = '0, irq_in = '0;
  logic [7:0] rdata, ack_vec, cas_word;
  logic       intr;
  int         checks = 0, errors = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  irq_ctl8 i_irq_ctl8 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .port_sel(port_sel), .wdata(wdata), .rdata(rdata), .irq_in(irq_in),
    .intr(intr), .inta(inta), .ack_vec(ack_vec), .cas_word(cas_word)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; port_sel = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); port_sel = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic line(input int idx, input logic v);
    @(negedge clk); irq_in[idx] = v;
    @(negedge clk);
  endtask

  // Driver: queues the expected vector and pulses acknowledge.
  task automatic ack(input logic [7:0] exp);
    @(negedge clk); exp_q.push_back(exp); inta = 1'b1;
    @(negedge clk); inta = 1'b0;
  endtask

  // Monitor: compares the vector presented at each acknowledge edge.
  always @(posedge clk) begin
    if (inta) begin
      if (exp_q.size() == 0) chk("R2 unexpected ack", ack_vec, 8'hxx);
      else chk("R2/R7 ack vector", ack_vec, exp_q.pop_front());
      chk("R7 intr at ack", {7'd0, intr}, 8'd1);
    end
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 reset intr", {7'd0, intr}, 8'd0);
    rd(1'b1, d); chk("R5 reset mask", d, 8'hFF);
    rd(1'b0, d); chk("R10 reset irr", d, 8'h00);

    // cascade, edge, mode byte without auto-EOI
    wr(1'b0, 8'h11);
    rd(1'b1, d); chk("R1 mask cleared", d, 8'h00);
    wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    chk("R3 cascade byte", cas_word, 8'h04);

    line(3, 1'b1); chk("R6 edge raises intr", {7'd0, intr}, 8'd1);
    ack(8'h23);
    chk("R6 edge consumed", {7'd0, intr}, 8'd0);
    wr(1'b0, 8'h0B);
    rd(1'b0, d); chk("R10 isr readback", d, 8'h08);
    line(5, 1'b1); chk("R7 lower blocked", {7'd0, intr}, 8'd0);
    line(1, 1'b1); chk("R7 higher preempts", {7'd0, intr}, 8'd1);
    ack(8'h21);
    rd(1'b0, d); chk("R7 nested isr", d, 8'h0A);
    wr(1'b0, 8'h20);
    rd(1'b0, d); chk("R9 eoi lowest", d, 8'h08);
    chk("R7 still blocked", {7'd0, intr}, 8'd0);
    wr(1'b0, 8'h20);
    chk("R9 unblocked", {7'd0, intr}, 8'd1);
    ack(8'h25);
    wr(1'b0, 8'h20);
    wr(1'b0, 8'h0A);
    rd(1'b0, d); chk("R10 irr select", d, 8'h00);
    wr(1'b0, 8'h0B);
    irq_in = '0;

    // masking
    wr(1'b1, 8'h04);
    line(2, 1'b1); chk("R5 masked", {7'd0, intr}, 8'd0);
    rd(1'b1, d); chk("R5 mask readback", d, 8'h04);
    wr(1'b1, 8'h00); chk("R5 unmasked", {7'd0, intr}, 8'd1);
    ack(8'h22);
    wr(1'b0, 8'h20);

    // special mask mode
    line(4, 1'b1); ack(8'h24);
    line(6, 1'b1); chk("R11 normal blocks", {7'd0, intr}, 8'd0);
    wr(1'b0, 8'h68); chk("R11 smm releases", {7'd0, intr}, 8'd1);
    ack(8'h26);
    rd(1'b0, d); chk("R11 both in service", d, 8'h50);
    wr(1'b0, 8'h48);
    wr(1'b0, 8'h20); wr(1'b0, 8'h20);
    rd(1'b0, d); chk("R9 all cleared", d, 8'h00);

    // poll
    line(7, 1'b1);
    wr(1'b0, 8'h0C);
    rd(1'b0, d); chk("R12 poll word", d, 8'h87);
    rd(1'b0, d); chk("R12 poll acked", d, 8'h80);
    chk("R12 intr after poll", {7'd0, intr}, 8'd0);
    wr(1'b0, 8'h20);
    irq_in = '0;
    @(negedge clk);

    // single, level, auto-EOI, new base
    wr(1'b0, 8'h1B);
    line(2, 1'b1); chk("R1 quiet during init", {7'd0, intr}, 8'd0);
    wr(1'b1, 8'h40); wr(1'b1, 8'h03);
    chk("R3 cascade skipped", cas_word, 8'h04);
    chk("R4 init done", {7'd0, intr}, 8'd1);
    ack(8'h42);
    rd(1'b0, d); chk("R6 level irr", d, 8'h04);
    wr(1'b0, 8'h0B);
    rd(1'b0, d); chk("R8 auto-EOI isr", d, 8'h00);
    line(2, 1'b0); @(negedge clk);
    chk("R6 level drop intr", {7'd0, intr}, 8'd0);
    wr(1'b0, 8'h0A);
    rd(1'b0, d); chk("R6 level irr clears", d, 8'h00);

    repeat (2) @(negedge clk);
    chk("R2 queue drained", 8'(exp_q.size()), 8'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule